// File: doc/BRIEF.md
# Fractional Baud Sample-Tick Generator

This block derives the two timing strobes a UART needs from a fast system clock. One strobe marks each of the sixteen samples in a bit. The other marks every sixteenth sample, which is the bit boundary. The clock ratio is usually not a whole number. An integer divisor therefore sets the base length of each sample period. A 16-bit slot mask then adds one clock to chosen samples, so the average period over a bit follows the fractional ratio.

Software sets the divisor to floor(f_clk / (16 × baud)) − 1. It sets as many mask bits as sixteen times the fractional part of that quotient. For example, a 66 MHz clock at 115200 baud gives a divisor of 34 and a mask with 12 ones, such as 0xDDDD. Both values are loaded together by a one-cycle write strobe, and the write restarts the sequence. The strobes are plain one-cycle pulses. There is no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, both tick outputs are low. Reset loads a divisor of RST_DIV (default 34) and a mask of RST_SLOT (default 0xDDDD), and sets the sample index to 0. The first `sample_tick` comes RST_DIV + RST_SLOT[0] + 1 clock edges after reset is released, counting the release edge's following cycle as cycle 1.
- R2: The distance between successive `sample_tick` pulses is divisor + 1 clocks, plus one clock when the mask bit for that sample is 1.
- R3: The sample index counts 0,1,…,15 and then wraps to 0. Mask bit i (the LSB is bit 0) stretches sample i.
- R4: `bit_tick` is high only in the same cycle as the `sample_tick` that ends sample 15. It is therefore high exactly once in every 16 samples.
- R5: Any 16 consecutive sample periods that start at index 0 add up to 16 × (divisor + 1) + popcount(mask) clocks.
- R6: When `cfg_wr` is high at a clock edge, `cfg_div` and `cfg_slot` are captured and the period counter and sample index are cleared. The next `sample_tick` then comes divisor + mask[0] + 1 cycles after that edge.
- R7: While `cfg_wr` is low, changes on `cfg_div` and `cfg_slot` have no effect on the tick timing.
- R8: A divisor of 0 with an all-zero mask gives a `sample_tick` on every clock. `bit_tick` then fires every 16th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle strobe that loads the divisor and mask and restarts the sequence |
| cfg_div | input | DIV_W | Integer divisor (period length minus one) |
| cfg_slot | input | 16 | Stretch mask; bit i adds one clock to sample i |
| sample_tick | output | 1 | One-cycle pulse at the end of each sample period |
| bit_tick | output | 1 | One-cycle pulse at the end of sample 15 |

## Verification
The bench walks a table of divisor and mask pairs. Each pair is loaded while the previous pair is still ticking, and every period is timed across two frames.

- The realistic pair (34, 0xDDDD) checks the fractional average against the expected frame total.
- The masks 0x0001 and 0x8000 stretch only the first or only the last sample. They expose a mask that is indexed in the wrong order or off by one.
- The alternating masks 0xAAAA and 0x5555 catch swapped parity in the index.
- An all-ones mask and the all-zero divisor-0 case test both extremes of the period length.

Directed tests then cover reset and the restart latency. They also check that changing the configuration inputs without a write strobe leaves the period timing unchanged.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int SLOTS = 16;
  localparam int IDX_W = $clog2(SLOTS);
  typedef logic [SLOTS-1:0] slot_mask_t;
  typedef logic [IDX_W-1:0] slot_idx_t;
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
  import frac_baud_pkg::*;
#(
  parameter int         DIV_W    = 16,
  parameter int         RST_DIV  = 34,
  parameter slot_mask_t RST_SLOT = 16'hDDDD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DIV_W-1:0] div_in,
  input  slot_mask_t       slot_in,
  output logic [DIV_W-1:0] div_q,
  output slot_mask_t       slot_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(RST_DIV);
      slot_q <= RST_SLOT;
    end else if (wr) begin
      div_q  <= div_in;
      slot_q <= slot_in;
    end
  end

  // R6: a write captures both fields
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (div_q == $past(div_in)) && (slot_q == $past(slot_in)));

  // R7: without a write, the configuration holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(div_q) && $stable(slot_q));

endmodule

// File: rtl/fbg_slot_sel.sv
module fbg_slot_sel
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_q,
  input  slot_mask_t       slot_q,
  input  slot_idx_t        idx,
  output logic             stretch,
  output logic [CNT_W-1:0] limit
);

  logic [SLOTS-1:0] hit_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit_vec[g] = slot_q[g] && (idx == slot_idx_t'(g));
  end

  assign stretch = |hit_vec;
  assign limit   = {1'b0, div_q} + CNT_W'(stretch);

endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt
  import frac_baud_pkg::*;
#(
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic             wrap,
  output slot_idx_t        idx
);

  logic [CNT_W-1:0] cnt;

  assign hit  = (cnt == limit);
  assign wrap = hit && (idx == slot_idx_t'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
      idx <= '0;
    end else if (hit) begin
      cnt <= '0;
      idx <= idx + slot_idx_t'(1);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R2: the counter never passes the period end
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  // R3: the index advances by one per sample
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !restart) |=> idx == $past(idx) + slot_idx_t'(1));

  // R6: a restart clears the count and the index
  a_r6_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && (idx == '0));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int         DIV_W    = 16,
  parameter int         RST_DIV  = 34,
  parameter slot_mask_t RST_SLOT = 16'hDDDD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [15:0]      cfg_slot,
  output logic             sample_tick,
  output logic             bit_tick
);

  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  slot_mask_t       slot_q;
  slot_idx_t        idx;
  logic             stretch;
  logic [CNT_W-1:0] limit;
  logic             hit;
  logic             wrap;

  fbg_cfg_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV), .RST_SLOT(RST_SLOT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .div_in(cfg_div), .slot_in(cfg_slot),
    .div_q(div_q), .slot_q(slot_q)
  );

  fbg_slot_sel #(.DIV_W(DIV_W)) u_sel (
    .div_q(div_q), .slot_q(slot_q), .idx(idx), .stretch(stretch), .limit(limit)
  );

  fbg_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .limit(limit),
    .hit(hit), .wrap(wrap), .idx(idx)
  );

  assign sample_tick = rst_n && hit;
  assign bit_tick    = rst_n && wrap;

  // R4: a bit tick is always also a sample tick
  a_r4_bit_in_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  // R4: a bit tick is followed by sample index 0 (or a restart)
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> idx == '0);

  // R1: both ticks stay low during reset
  always_comb begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!sample_tick && !bit_tick);
  end

endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [15:0] cfg_slot = '0;
  logic        sample_tick;
  logic        bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_slot(cfg_slot), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // {divisor, mask}
  localparam logic [31:0] VEC [7] = '{
    {16'd34, 16'hDDDD},
    {16'd0,  16'h0000},
    {16'd3,  16'h0001},
    {16'd5,  16'h8000},
    {16'd2,  16'hAAAA},
    {16'd1,  16'h5555},
    {16'd0,  16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called on the negedge that is cycle 1 of a fresh period at index 0.
  task automatic measure(input int dv, input logic [15:0] sl, input int frames, input string tag);
    int sum = 0;
    for (int k = 0; k < 16 * frames; k++) begin
      int gap = 1;
      int exp_gap = dv + 1 + int'(sl[k % 16]);
      while (!sample_tick && gap < 2000) begin
        @(negedge clk);
        gap++;
      end
      if (k == 0)
        chk(gap == exp_gap, {"R6 first latency ", tag}, gap, exp_gap);
      else
        chk(gap == exp_gap, {"R2/R3 period ", tag}, gap, exp_gap);
      chk(bit_tick == ((k % 16) == 15), {"R4 bit tick ", tag}, int'(bit_tick), int'((k % 16) == 15));
      sum += gap;
      if ((k % 16) == 15) begin
        chk(sum == 16 * (dv + 1) + $countones(sl), {"R5 frame sum ", tag}, sum, 16 * (dv + 1) + $countones(sl));
        sum = 0;
      end
      @(negedge clk);
    end
  endtask

  task automatic load(input logic [15:0] dv, input logic [15:0] sl);
    cfg_div  = dv;
    cfg_slot = sl;
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  initial begin
    // R1: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!sample_tick && !bit_tick, "R1 ticks low in reset", int'(sample_tick | bit_tick), 0);
    end
    rst_n = 1'b1;
    // R1: reset configuration 34 / 0xDDDD
    measure(34, 16'hDDDD, 1, "R1 reset config");

    // Vector table; each load lands mid-run (R6 restart)
    for (int v = 0; v < 7; v++) begin
      load(VEC[v][31:16], VEC[v][15:0]);
      measure(int'(VEC[v][31:16]), VEC[v][15:0], 2,
              (VEC[v][31:16] == 0 && VEC[v][15:0] == 0) ? "R8 every clock" : "table");
    end

    // R6: restart in the middle of a long period
    load(16'd20, 16'h0003);
    repeat (7) @(negedge clk);
    load(16'd4, 16'h0001);
    measure(4, 16'h0001, 1, "R6 mid-period restart");

    // R7: input changes without a write strobe are ignored
    cfg_div  = 16'd9;
    cfg_slot = 16'hFFFF;
    measure(4, 16'h0001, 1, "R7 inputs ignored");

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(!sample_tick && !bit_tick, "R1 ticks low on reset", int'(sample_tick | bit_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure(34, 16'hDDDD, 1, "R1 reset restores defaults");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule